// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where subroutine returns will go, for use at the fetch stage. Each time fetch sees a call, the block stores the address of the instruction that follows the call, which is the call PC plus the fixed 4-byte instruction size. Each time fetch sees a return, the block removes the most recent stored address and gives it as the predicted target in that same cycle. The store is a small circular buffer with a top pointer and an occupancy count.

An elaboration parameter selects what happens when a call arrives while the stack is full. In the overwrite policy the new address replaces the oldest entry. The most recent DEPTH returns are then predicted correctly, and the return that would have needed the lost entry finds the stack empty. In the hold policy the call is dropped and the stack is left as it was. The return that matches the dropped call therefore gets the newest surviving entry, which is a stale address. Repair after a misprediction and checkpointing are outside this block.

Top module: `ras_predictor`

## Requirements
- R1: A synchronous active-high reset empties the stack. A return presented after reset gives pred_valid_o=0 and pred_addr_o=0.
- R2: A call pushes call_pc_i + 4, computed modulo 2^32, so a call at 0xFFFFFFFC pushes 0x00000000.
- R3: A return on a non-empty stack drives pred_valid_o=1 and pred_addr_o equal to the top entry in the same cycle. The top entry is then removed at the clock edge.
- R4: Returns give the pushed addresses in last-in first-out order.
- R5: A return on an empty stack gives pred_valid_o=0 and pred_addr_o=0 and leaves the stack unchanged. Later calls and returns behave as if that return had not happened.
- R6: In a cycle with no return, pred_valid_o=0 and pred_addr_o=0.
- R7: Overwrite policy (OVF_POLICY=OVF_WRAP): a call on a full stack replaces the oldest entry and occupancy stays at DEPTH. The next DEPTH returns predict the newest DEPTH addresses, and the return after them gets pred_valid_o=0.
- R8: Hold policy (OVF_POLICY=OVF_HOLD): a call on a full stack, with no return in the same cycle, is ignored. The next return predicts the top entry that was present before that call.
- R9: When a call and a return arrive in the same cycle, the return is applied first and predicts the old top, then the call pushes. On a non-empty stack occupancy is unchanged and the old top is replaced. On an empty stack the result is one entry.
- R10: Occupancy never exceeds DEPTH and never goes below zero, whatever the sequence of calls and returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | A call was seen this cycle |
| ret_i | input | 1 | A return was seen this cycle |
| call_pc_i | input | 32 | PC of the call instruction |
| pred_valid_o | output | 1 | The predicted return target is valid |
| pred_addr_o | output | 32 | Predicted return target, zero when not valid |

## Verification
Wrong internal state stays hidden until a return reads it. A pointer that is off by one, or a write that goes to the wrong entry, shows up as a wrong pred_addr_o on the first return that reaches the damaged slot. A bad occupancy count shows up as a wrong pred_valid_o: either a valid flag on an empty stack, or a missing flag at the end of an overflow sequence. Each port value is therefore compared with a queue model in every cycle, and the sequences used (deep overflow, paired call and return, returns past the bottom) make sure every slot and both ends of the count are read back within a few cycles of being written.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int unsigned RAS_ADDR_W     = 32;
    localparam int unsigned RAS_DEPTH      = 4;
    localparam int unsigned RAS_INST_BYTES = 4;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_HOLD = 1'b1
    } ovf_policy_e;

    typedef struct packed {
        logic call;
        logic ret;
    } ras_req_t;

    function automatic logic [RAS_ADDR_W-1:0] link_addr(input logic [RAS_ADDR_W-1:0] pc);
        return pc + RAS_ADDR_W'(RAS_INST_BYTES);
    endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
    parameter int unsigned          DEPTH      = ras_pkg::RAS_DEPTH,
    parameter ras_pkg::ovf_policy_e OVF_POLICY = ras_pkg::OVF_WRAP,
    parameter int unsigned          PTR_W      = $clog2(DEPTH),
    parameter int unsigned          CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  ras_pkg::ras_req_t    req,
    output logic                 pop_fire,
    output logic                 wr_en,
    output logic [PTR_W-1:0]     wr_idx,
    output logic [PTR_W-1:0]     top_ptr,
    output logic [CNT_W-1:0]     occ
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0] top_q, top_after_pop, top_d;
    logic [CNT_W-1:0] cnt_q, cnt_after_pop, cnt_d;
    logic             push_ok;

    // the return is applied first, then the call
    always_comb begin
        pop_fire      = req.ret && (cnt_q != '0);
        top_after_pop = pop_fire ? top_q - PTR_W'(1) : top_q;
        cnt_after_pop = pop_fire ? cnt_q - CNT_W'(1) : cnt_q;
    end

    generate
        if (OVF_POLICY == ras_pkg::OVF_HOLD) begin : g_hold
            always_comb push_ok = req.call && (cnt_after_pop != FULL_CNT);
        end else begin : g_wrap
            always_comb push_ok = req.call;
        end
    endgenerate

    always_comb begin
        wr_en  = push_ok;
        wr_idx = top_after_pop + PTR_W'(1);
        top_d  = push_ok ? wr_idx : top_after_pop;
        cnt_d  = cnt_after_pop;
        if (push_ok && cnt_after_pop != FULL_CNT)
            cnt_d = cnt_after_pop + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            cnt_q <= '0;
        end else begin
            top_q <= top_d;
            cnt_q <= cnt_d;
        end
    end

    assign top_ptr = top_q;
    assign occ     = cnt_q;
endmodule

// File: rtl/ras_storage.sv
module ras_storage #(
    parameter int unsigned DEPTH  = ras_pkg::RAS_DEPTH,
    parameter int unsigned ADDR_W = ras_pkg::RAS_ADDR_W,
    parameter int unsigned PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst)
                    slot_q[s] <= '0;
                else if (wr_en && wr_idx == PTR_W'(s))
                    slot_q[s] <= wr_data;
            end
        end
    endgenerate

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/ras_pred_out.sv
module ras_pred_out #(
    parameter int unsigned ADDR_W = ras_pkg::RAS_ADDR_W
) (
    input  logic              pop_fire,
    input  logic [ADDR_W-1:0] top_data,
    output logic              pred_valid,
    output logic [ADDR_W-1:0] pred_addr
);
    always_comb begin
        pred_valid = pop_fire;
        pred_addr  = pop_fire ? top_data : '0;
    end
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
    parameter int unsigned          DEPTH      = ras_pkg::RAS_DEPTH,
    parameter int unsigned          ADDR_W     = ras_pkg::RAS_ADDR_W,
    parameter ras_pkg::ovf_policy_e OVF_POLICY = ras_pkg::OVF_WRAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] call_pc_i,
    output logic              pred_valid_o,
    output logic [ADDR_W-1:0] pred_addr_o
);
    // DEPTH must be a power of two and at least 2 for the pointer to wrap cleanly
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    ras_pkg::ras_req_t req;
    logic              pop_fire, wr_en;
    logic [PTR_W-1:0]  wr_idx, top_ptr;
    logic [CNT_W-1:0]  occ;
    logic [ADDR_W-1:0] top_data, push_data;

    assign req.call  = call_i;
    assign req.ret   = ret_i;
    assign push_data = ras_pkg::link_addr(call_pc_i);

    ras_ptr_ctrl #(
        .DEPTH(DEPTH), .OVF_POLICY(OVF_POLICY), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .req(req), .pop_fire(pop_fire), .wr_en(wr_en),
        .wr_idx(wr_idx), .top_ptr(top_ptr), .occ(occ)
    );

    ras_storage #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(push_data),
        .rd_idx(top_ptr), .rd_data(top_data)
    );

    ras_pred_out #(.ADDR_W(ADDR_W)) u_out (
        .pop_fire(pop_fire), .top_data(top_data),
        .pred_valid(pred_valid_o), .pred_addr(pred_addr_o)
    );
endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int unsigned          DEPTH      = ras_pkg::RAS_DEPTH,
    parameter int unsigned          ADDR_W     = ras_pkg::RAS_ADDR_W,
    parameter ras_pkg::ovf_policy_e OVF_POLICY = ras_pkg::OVF_WRAP,
    parameter int unsigned          PTR_W      = $clog2(DEPTH),
    parameter int unsigned          CNT_W      = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              call_i,
    input logic              ret_i,
    input logic [ADDR_W-1:0] call_pc_i,
    input logic              pred_valid_o,
    input logic [ADDR_W-1:0] top_data,
    input logic [PTR_W-1:0]  top_ptr,
    input logic [CNT_W-1:0]  occ
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    assert_push_value_R2: assert property (@(posedge clk) disable iff (rst)
        (call_i && !ret_i && occ != FULL_CNT) |=> top_data == $past(call_pc_i) + ADDR_W'(4));

    assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && occ != '0) |=> occ == $past(occ) - CNT_W'(1));

    assert_empty_pop_invalid_R5: assert property (@(posedge clk) disable iff (rst)
        (ret_i && occ == '0) |-> !pred_valid_o);

    assert_empty_pop_still_R5: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && occ == '0) |=> ($stable(occ) && $stable(top_ptr)));

    assert_wrap_saturate_R7: assert property (@(posedge clk) disable iff (rst)
        (OVF_POLICY == ras_pkg::OVF_WRAP && call_i && !ret_i && occ == FULL_CNT) |=> occ == FULL_CNT);

    assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (OVF_POLICY == ras_pkg::OVF_HOLD && call_i && !ret_i && occ == FULL_CNT)
        |=> ($stable(top_ptr) && $stable(top_data) && $stable(occ)));

    assert_pair_keeps_count_R9: assert property (@(posedge clk) disable iff (rst)
        (call_i && ret_i && occ != '0) |=> $stable(occ));

    assert_occupancy_bound_R10: assert property (@(posedge clk) disable iff (rst)
        occ <= FULL_CNT);
endmodule

bind ras_predictor ras_checker #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .OVF_POLICY(OVF_POLICY), .PTR_W(PTR_W), .CNT_W(CNT_W)
) u_ras_chk (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i), .call_pc_i(call_pc_i),
    .pred_valid_o(pred_valid_o), .top_data(top_data), .top_ptr(top_ptr), .occ(occ)
);

// File: tb/tb_ras_predictor.sv
module tb_ras_predictor;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst, call, ret;
    logic [31:0] pc;
    logic        v_wrap, v_hold;
    logic [31:0] a_wrap, a_hold;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [31:0] q_wrap[$];
    logic [31:0] q_hold[$];

    always #10 clk = ~clk;

    ras_predictor #(.OVF_POLICY(ras_pkg::OVF_WRAP)) dut (
        .clk(clk), .rst(rst), .call_i(call), .ret_i(ret), .call_pc_i(pc),
        .pred_valid_o(v_wrap), .pred_addr_o(a_wrap));

    ras_predictor #(.OVF_POLICY(ras_pkg::OVF_HOLD)) dut_hold (
        .clk(clk), .rst(rst), .call_i(call), .ret_i(ret), .call_pc_i(pc),
        .pred_valid_o(v_hold), .pred_addr_o(a_hold));

    task automatic compare(input string tag, input string which,
                           input logic av, input logic [31:0] aa,
                           input logic ev, input logic [31:0] ea);
        vectors++;
        if (av !== ev || aa !== ea) begin
            miscompares++;
            $display("FAIL %s %s: got valid=%0b addr=%08h, expected valid=%0b addr=%08h",
                     tag, which, av, aa, ev, ea);
        end
    endtask

    task automatic model_step(ref logic [31:0] q[$], input bit hold, input bit c,
                              input bit r, input logic [31:0] p);
        if (r && q.size() > 0) void'(q.pop_back());
        if (c) begin
            if (!hold || q.size() < DEPTH) q.push_back(p + 32'd4);
            if (q.size() > DEPTH) void'(q.pop_front());
        end
    endtask

    task automatic step(input bit c, input bit r, input logic [31:0] p, input string tag);
        logic        ev;
        logic [31:0] ea;
        @(negedge clk);
        call = c; ret = r; pc = p;
        #5;
        ev = r && q_wrap.size() > 0;
        ea = ev ? q_wrap[$] : 32'd0;
        compare(tag, "wrap", v_wrap, a_wrap, ev, ea);
        ev = r && q_hold.size() > 0;
        ea = ev ? q_hold[$] : 32'd0;
        compare(tag, "hold", v_hold, a_hold, ev, ea);
        model_step(q_wrap, 1'b0, c, r, p);
        model_step(q_hold, 1'b1, c, r, p);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; call = 1'b0; ret = 1'b0; pc = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        q_wrap.delete();
        q_hold.delete();
    endtask

    initial begin
        rst = 1'b1; call = 1'b0; ret = 1'b0; pc = '0;
        do_reset();

        step(0, 1, 32'h0, "R1");                 // reset state: empty
        step(0, 0, 32'h0, "R6");                 // idle
        step(1, 0, 32'h0000FC34, "R2");
        step(0, 1, 32'h0, "R2");                 // expect 0000FC38
        step(1, 0, 32'hFFFFFFFC, "R2");
        step(0, 1, 32'h0, "R2");                 // expect 00000000 valid
        step(1, 0, 32'h1000, "R4");
        step(1, 0, 32'h2000, "R6");
        step(1, 0, 32'h3000, "R4");
        for (int i = 0; i < 3; i++) step(0, 1, 32'h0, "R3");
        step(0, 1, 32'h0, "R5");                 // empty again
        step(0, 1, 32'h0, "R5");
        step(1, 0, 32'h4400, "R5");
        step(0, 1, 32'h0, "R5");                 // behaves normally after empty pops

        // overflow: five calls into four slots, then six returns
        for (int i = 0; i < 5; i++) step(1, 0, 32'hA000 + 32'(i * 16), "R7");
        for (int i = 0; i < 6; i++) step(0, 1, 32'h0, "R8");
        // hold: extra calls while full, then returns
        for (int i = 0; i < 6; i++) step(1, 0, 32'hB000 + 32'(i * 16), "R8");
        for (int i = 0; i < 5; i++) step(0, 1, 32'h0, "R7");

        // paired call and return
        step(1, 1, 32'hC000, "R9");              // on empty stack
        step(1, 0, 32'hC100, "R9");
        step(1, 1, 32'hC200, "R9");              // replaces top
        for (int i = 0; i < 3; i++) step(0, 1, 32'h0, "R9");
        for (int i = 0; i < 4; i++) step(1, 0, 32'hD000 + 32'(i * 8), "R9");
        step(1, 1, 32'hD100, "R9");              // full and paired
        for (int i = 0; i < 5; i++) step(0, 1, 32'h0, "R9");

        // reset clears a populated stack
        step(1, 0, 32'hE000, "R1");
        do_reset();
        step(0, 1, 32'h0, "R1");

        // long mixed stream
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom & 32'hFFFFFFFC, "R10");

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule